// File: doc/BRIEF.md
# Serial Transmit Line Encoder

The block turns a serial transmit bit stream into a line signal. It supports four codes: plain NRZ, NRZI with a toggle on zero, NRZI with a toggle on one, and FM0. It runs from an oversampled transmit clock. It either divides that clock down to the bit rate by a fixed ratio `DIV`, or runs in 1x mode, where every clock edge starts a new bit slot.

Before the payload, the block can send a preamble that gives a far-end clock-recovery loop the edges it needs to lock. The preamble pattern is picked from the selected code. The preamble length can be programmed and is never shorter than eight slots. The final level can be inverted before it drives the line.

Payload bits arrive over a ready/valid handshake, one bit per slot. The block captures its configuration only while transmit is disabled. Dropping the enable returns the line to its idle level and clears all encoder state.

Top module: `tx_line_encoder`

## Requirements
- R1: With `enc_sel_i` = 0 (NRZ), the pre-inversion line level during a slot equals the bit sent in that slot.
- R2: With `enc_sel_i` = 1 (NRZI toggle-on-zero), a 0 bit flips the line at the slot boundary and a 1 bit keeps it unchanged.
- R3: With `enc_sel_i` = 2 (NRZI toggle-on-one), a 1 bit flips the line at the slot boundary and a 0 bit keeps it unchanged.
- R4: With `enc_sel_i` = 3 (FM0), the line flips at every slot boundary. For a 0 bit it flips again `DIV/2` clocks into the slot.
- R5: When `pre_en_i` is set, preamble slots come before the payload. Their bits are all 0 for code 1, all 1 for codes 2 and 3, and alternate 0,1,0,... starting with 0 for code 0.
- R6: The number of preamble slots is `pre_len_i`, raised to 8 when it is below 8. With `pre_en_i` clear, no preamble is sent.
- R7: In divided mode each slot lasts `DIV` clocks. In 1x mode (`one_x_i` = 1) each slot lasts one clock, except with FM0, which always uses divided timing. The first slot boundary is the first clock edge at which `tx_en_i` is high.
- R8: After the preamble, `ready_o` is high for exactly the one clock that opens each slot, and a bit is taken when `valid_i` and `ready_o` are both high. If `valid_i` is low at that moment, the slot carries an idle 1 bit and `active_o` is low for it.
- R9: `line_o` equals the encoded level XOR the captured invert setting, including while idle.
- R10: While `tx_en_i` is low or `rst_ni` is low, the pre-inversion line level is 1 and `active_o` and `ready_o` are 0. Dropping `tx_en_i` takes effect at the next clock edge and restarts the sequence on re-enable.
- R11: Code, preamble, 1x and invert settings are captured only while `tx_en_i` is low. Changes while it is high have no effect on the line.
- R12: `active_o` is high, aligned with `line_o`, for every preamble slot and every slot carrying a payload bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampled transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable; low idles the line and clears state |
| enc_sel_i | input | 2 | Code: 0 NRZ, 1 NRZI toggle-on-zero, 2 NRZI toggle-on-one, 3 FM0 |
| pre_en_i | input | 1 | Send a preamble before the payload |
| pre_len_i | input | PRE_LEN_W | Preamble length in slots (minimum 8 applied) |
| one_x_i | input | 1 | 1x mode: one slot per clock |
| inv_i | input | 1 | Invert the line output |
| data_i | input | 1 | Payload bit |
| valid_i | input | 1 | Payload bit is valid |
| ready_o | output | 1 | Payload bit is taken at this edge |
| line_o | output | 1 | Encoded line bit |
| active_o | output | 1 | Current slot carries preamble or payload |

## Verification
On every cycle, the assertions check several properties. The line never moves between slot boundaries or FM0 mid-points. FM0 always flips at a boundary. A 1 bit holds the line in toggle-on-zero NRZI. The boundary and mid-bit strobes never coincide, and divided boundaries never come on adjacent clocks. The preamble does not end before its count runs out. Disabling idles the line and clears the activity flag. Only the bench scenarios can show the level sequence of each code against an independent model, the preamble pattern and the minimum length of eight, the idle slot inserted on an underrun, and that mid-transmission changes to the configuration are ignored.

// File: rtl/txenc_pkg.sv
package txenc_pkg;
  typedef enum logic [1:0] {
    ENC_NRZ    = 2'd0,
    ENC_NRZI_Z = 2'd1,
    ENC_NRZI_O = 2'd2,
    ENC_FM0    = 2'd3
  } enc_e;

  typedef enum logic {
    ST_PRE  = 1'b0,
    ST_DATA = 1'b1
  } seq_e;

  typedef struct packed {
    enc_e enc;
    logic pre_en;
    logic one_x;
    logic inv;
  } cfg_t;
endpackage

// File: rtl/txenc_timing.sv
module txenc_timing #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic one_x_i,
  output logic bnd_o,
  output logic mid_o
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign bnd_o = en_i && (one_x_i || cnt_q == '0);
  assign mid_o = en_i && !one_x_i && (cnt_q == CW'(HALF));

  initial begin
    if (DIV < 2) $error("DIV must be at least 2");
  end

  AST_BND_MID_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> !(bnd_o && mid_o)); // R4
  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bnd_o && !one_x_i) |=> !bnd_o); // R7
endmodule

// File: rtl/txenc_seq.sv
module txenc_seq
  import txenc_pkg::*;
#(
  parameter int PRE_LEN_W = 5,
  parameter int PRE_MIN   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 bnd_i,
  input  enc_e                 enc_i,
  input  logic                 pre_en_i,
  input  logic [PRE_LEN_W-1:0] pre_len_i,
  input  logic                 data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic                 bit_o,
  output logic                 act_o
);
  localparam int MW = $clog2(PRE_MIN + 1);
  localparam int CW = (PRE_LEN_W > MW) ? PRE_LEN_W : MW;

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          act_q;
  logic [CW-1:0] load_len;
  logic          pre_bit;

  assign load_len = (CW'(pre_len_i) < CW'(PRE_MIN)) ? CW'(PRE_MIN) : CW'(pre_len_i);

  always_comb begin
    unique case (enc_i)
      ENC_NRZ:    pre_bit = ph_q;
      ENC_NRZI_Z: pre_bit = 1'b0;
      default:    pre_bit = 1'b1;
    endcase
  end

  assign ready_o = bnd_i && (st_q == ST_DATA);
  assign bit_o   = (st_q == ST_PRE) ? pre_bit : (valid_i ? data_i : 1'b1);
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_DATA;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (!en_i) begin
      st_q  <= pre_en_i ? ST_PRE : ST_DATA;
      cnt_q <= load_len;
      ph_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (bnd_i) begin
      if (st_q == ST_PRE) begin
        cnt_q <= cnt_q - 1'b1;
        ph_q  <= ~ph_q;
        act_q <= 1'b1;
        if (cnt_q == CW'(1)) st_q <= ST_DATA;
      end else begin
        act_q <= valid_i;
      end
    end
  end

  AST_PRE_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bnd_i && st_q == ST_PRE && cnt_q > CW'(1)) |=> st_q == ST_PRE); // R6
  AST_PRE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bnd_i && st_q == ST_PRE) |=> act_o); // R12
  AST_ACT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !act_o); // R10
endmodule

// File: rtl/txenc_coder.sv
module txenc_coder
  import txenc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bnd_i,
  input  logic mid_i,
  input  enc_e enc_i,
  input  logic bit_i,
  input  logic inv_i,
  output logic line_o
);
  logic line_q;
  logic bit_q;
  logic line_d;

  always_comb begin
    unique case (enc_i)
      ENC_NRZ:    line_d = bit_i;
      ENC_NRZI_Z: line_d = bit_i ? line_q : ~line_q;
      ENC_NRZI_O: line_d = bit_i ? ~line_q : line_q;
      default:    line_d = ~line_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      bit_q  <= 1'b1;
    end else if (!en_i) begin
      line_q <= 1'b1;
      bit_q  <= 1'b1;
    end else if (bnd_i) begin
      line_q <= line_d;
      bit_q  <= bit_i;
    end else if (mid_i && enc_i == ENC_FM0 && !bit_q) begin
      line_q <= ~line_q;
    end
  end

  assign line_o = line_q ^ inv_i;

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> line_q); // R10
  AST_FM0_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bnd_i && enc_i == ENC_FM0) |=> line_q != $past(line_q)); // R4
  AST_ZERO_NRZI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bnd_i && enc_i == ENC_NRZI_Z && bit_i) |=> $stable(line_q)); // R2
  AST_QUIET_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bnd_i && !mid_i) |=> $stable(line_q)); // R7
endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
  import txenc_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int PRE_LEN_W = 5,
  parameter int PRE_MIN   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tx_en_i,
  input  logic [1:0]           enc_sel_i,
  input  logic                 pre_en_i,
  input  logic [PRE_LEN_W-1:0] pre_len_i,
  input  logic                 one_x_i,
  input  logic                 inv_i,
  input  logic                 data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic                 line_o,
  output logic                 active_o
);
  cfg_t                 cfg_q;
  logic [PRE_LEN_W-1:0] len_q;
  logic                 one_x_eff;
  logic                 bnd;
  logic                 mid;
  logic                 enc_bit;

  // settings are only sampled while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{enc: ENC_NRZ, pre_en: 1'b0, one_x: 1'b0, inv: 1'b0};
      len_q <= '0;
    end else if (!tx_en_i) begin
      cfg_q <= '{enc: enc_e'(enc_sel_i), pre_en: pre_en_i, one_x: one_x_i, inv: inv_i};
      len_q <= pre_len_i;
    end
  end

  // FM0 needs a mid-bit point, so it always runs divided
  assign one_x_eff = cfg_q.one_x && (cfg_q.enc != ENC_FM0);

  txenc_timing #(.DIV(DIV)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tx_en_i),
    .one_x_i (one_x_eff),
    .bnd_o   (bnd),
    .mid_o   (mid)
  );

  txenc_seq #(.PRE_LEN_W(PRE_LEN_W), .PRE_MIN(PRE_MIN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .bnd_i     (bnd),
    .enc_i     (cfg_q.enc),
    .pre_en_i  (cfg_q.pre_en),
    .pre_len_i (len_q),
    .data_i    (data_i),
    .valid_i   (valid_i),
    .ready_o   (ready_o),
    .bit_o     (enc_bit),
    .act_o     (active_o)
  );

  txenc_coder u_coder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_i),
    .bnd_i  (bnd),
    .mid_i  (mid),
    .enc_i  (cfg_q.enc),
    .bit_i  (enc_bit),
    .inv_i  (cfg_q.inv),
    .line_o (line_o)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i)) |-> $stable(cfg_q)); // R11
endmodule

// File: tb/tx_line_encoder_tb.sv
`timescale 1ns/1ps
module tx_line_encoder_tb;
  localparam int DIV = 4;
  localparam int H   = DIV / 2;

  typedef struct packed {
    logic [1:0] enc;
    logic       pre_en;
    logic [4:0] len;
    logic       onex;
    logic       inv;
    logic [7:0] data;
    logic [3:0] gap;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 8'hA5, 4'd15},
    '{2'd1, 1'b1, 5'd3,  1'b0, 1'b0, 8'h3C, 4'd15},
    '{2'd2, 1'b1, 5'd10, 1'b1, 1'b0, 8'h96, 4'd3},
    '{2'd3, 1'b1, 5'd8,  1'b1, 1'b1, 8'h4D, 4'd15},
    '{2'd0, 1'b1, 5'd9,  1'b0, 1'b1, 8'hF0, 4'd15},
    '{2'd1, 1'b0, 5'd0,  1'b1, 1'b0, 8'h00, 4'd5},
    '{2'd3, 1'b0, 5'd0,  1'b0, 1'b0, 8'hFF, 4'd0},
    '{2'd2, 1'b1, 5'd0,  1'b0, 1'b0, 8'h01, 4'd15}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, pre_en, one_x, inv, data, valid;
  logic [1:0] enc_sel;
  logic [4:0] pre_len;
  logic       ready, line, active;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic samp [512];
  logic sact [512];
  logic ea   [64];
  logic eb   [64];
  logic eact [64];

  always #2.5 clk = ~clk;

  tx_line_encoder #(.DIV(DIV), .PRE_LEN_W(5), .PRE_MIN(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .enc_sel_i(enc_sel),
    .pre_en_i(pre_en), .pre_len_i(pre_len), .one_x_i(one_x), .inv_i(inv),
    .data_i(data), .valid_i(valid), .ready_o(ready), .line_o(line),
    .active_o(active)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    int d, p, g, slots, ncyc, idx, gapped, gd, didx, rdy, lvl, b, a, bb, b0;
    bit take, ok;
    string tag;
    tx_en = 1'b0; valid = 1'b0;
    enc_sel = v.enc; pre_en = v.pre_en; pre_len = v.len; one_x = v.onex; inv = v.inv;
    repeat (4) @(negedge clk);
    d = (v.onex && v.enc != 2'd3) ? 1 : DIV;
    p = v.pre_en ? ((v.len < 8) ? 8 : int'(v.len)) : 0;
    g = (v.gap < 8) ? 1 : 0;
    slots = p + 8 + g + 2;
    ncyc = slots * d;
    // reference model
    lvl = 1; didx = 0; gd = 0;
    for (int k = 0; k < slots; k++) begin
      eact[k] = 1'b1;
      if (k < p) begin
        b = (v.enc == 2'd0) ? (k % 2) : ((v.enc == 2'd1) ? 0 : 1);
      end else if (didx < 8 && !(g == 1 && didx == int'(v.gap) && gd == 0)) begin
        b = int'(v.data[didx]); didx++;
      end else begin
        if (didx < 8) gd = 1;
        b = 1; eact[k] = 1'b0;
      end
      case (v.enc)
        2'd0: begin lvl = b; a = lvl; bb = lvl; end
        2'd1: begin if (b == 0) lvl ^= 1; a = lvl; bb = lvl; end
        2'd2: begin if (b == 1) lvl ^= 1; a = lvl; bb = lvl; end
        default: begin lvl ^= 1; a = lvl; if (b == 0) lvl ^= 1; bb = lvl; end
      endcase
      ea[k] = 1'(a) ^ v.inv;
      eb[k] = 1'(bb) ^ v.inv;
    end
    // drive and capture
    idx = 0; gapped = 0; rdy = 0;
    valid = !(g == 1 && idx == int'(v.gap));
    data = v.data[0];
    tx_en = 1'b1;
    #1;
    for (int c = 0; c < ncyc; c++) begin
      take = ready && valid;
      if (ready && !valid && idx < 8) gapped = 1;
      if (ready) rdy++;
      @(posedge clk);
      #1;
      if (take) idx++;
      valid = (idx < 8) && !(g == 1 && idx == int'(v.gap) && gapped == 0);
      data = (idx < 8) ? v.data[idx] : 1'b1;
      @(negedge clk);
      samp[c] = line;
      sact[c] = active;
    end
    tx_en = 1'b0; valid = 1'b0;
    for (int k = 0; k < slots; k++) begin
      b0 = k * d;
      ok = (samp[b0] == ea[k]) && (sact[b0] == eact[k]);
      if (d > 1)
        ok = ok && samp[b0+H-1] == ea[k] && samp[b0+H] == eb[k] &&
             samp[b0+d-1] == eb[k] && sact[b0+d-1] == eact[k];
      case (v.enc)
        2'd0: tag = "R1";
        2'd1: tag = "R2";
        2'd2: tag = "R3";
        default: tag = "R4";
      endcase
      if (k < p) tag = {tag, " R5 R6"};
      if (v.onex) tag = {tag, " R7"};
      if (v.inv) tag = {tag, " R9"};
      tag = $sformatf("%s R12 vec %0d slot %0d line,act", tag, vi, k);
      chk(ok, tag, {samp[b0], samp[b0+d-1], sact[b0]}, {ea[k], eb[k], eact[k]});
    end
    chk(idx == 8, $sformatf("R8 vec %0d bits taken", vi), idx, 8);
    chk(rdy == slots - p, $sformatf("R8 vec %0d ready pulses", vi), rdy, slots - p);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got %0d exp %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int okc;
    rst_n = 1'b0; tx_en = 1'b0; enc_sel = 2'd0; pre_en = 1'b0; pre_len = 5'd0;
    one_x = 1'b0; inv = 1'b0; data = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(line == 1'b1, "R10 reset line", int'(line), 1);
    chk(active == 1'b0, "R12 reset active", int'(active), 0);
    chk(ready == 1'b0, "R8 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: idle level inverted
    inv = 1'b1;
    repeat (2) @(negedge clk);
    chk(line == 1'b0, "R9 idle inverted", int'(line), 0);
    inv = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

    // R10: disable mid-transmission
    enc_sel = 2'd0; pre_en = 1'b0; one_x = 1'b0; inv = 1'b0; data = 1'b0; valid = 1'b1;
    repeat (3) @(negedge clk);
    tx_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(line == 1'b0 && active == 1'b1, "R1 zero before disable", {line, active}, 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk(line == 1'b1, "R10 line idles after disable", int'(line), 1);
    chk(active == 1'b0 && ready == 1'b0, "R10 active,ready after disable", {active, ready}, 0);

    // R11: settings changed while enabled are ignored
    repeat (3) @(negedge clk);
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    enc_sel = 2'd1; inv = 1'b1; one_x = 1'b1;
    okc = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (line == 1'b0 && active == 1'b1) okc++;
    end
    chk(okc == 12, "R11 line unchanged by mid-run settings", okc, 12);
    tx_en = 1'b0; valid = 1'b0; enc_sel = 2'd0; inv = 1'b0; one_x = 1'b0;
    repeat (3) @(negedge clk);
    chk(line == 1'b1, "R10 idle after run", int'(line), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule